// File: doc/BRIEF.md
# Plus-Three Pair Event Lamp

This block watches a stream of digit pairs, each given as a signed 7-bit difference with a one-cycle valid strobe. It counts the pairs whose difference is exactly +3. It drives a lamp that comes on at the second such pair and goes off at the third. After that the count starts again from zero, so the lamp toggles on every second and third qualifying pair of each repeating group.

Pairs with any other difference may arrive between qualifying pairs, and they leave the count unchanged. The whole history is held in a 2-bit state register, well under a budget of five flip-flops. The lamp level is decoded from that state, so it changes one clock after the edge that samples the deciding pair.

Top module: `pair_match_lamp`

## Requirements
- R1: While `rst_n` is low the lamp is off and the block is idle, even if a qualifying pair is presented. After release, the next qualifying pair counts as the first of a new group.
- R2: A pair qualifies only when `pair_valid_i` is high and `pair_diff_i` equals +3 (7'b0000011) on a rising clock edge.
- R3: A pair with difference -3 (7'b1111101), or any value other than +3, never changes the count or the lamp.
- R4: A difference of +3 presented while `pair_valid_i` is low is ignored.
- R5: The lamp rises in the cycle after the edge that samples the second qualifying pair of a group.
- R6: Non-qualifying pairs between two qualifying pairs do not disturb the count, so separated qualifying pairs light the lamp as consecutive ones do.
- R7: Once lit, the lamp stays on through any number of non-qualifying pairs. It falls in the cycle after the third qualifying pair is sampled.
- R8: After the lamp falls, counting restarts from zero: one further qualifying pair leaves it off, and the next lights it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| pair_valid_i | input | 1 | High for one cycle per arriving pair |
| pair_diff_i | input | 7 | Signed two's-complement difference of the pair |
| lamp_o | output | 1 | Indicator lamp level |

## Verification
Two things can fall in the same cycle: reset being held, and a qualifying pair being offered. The bench holds `rst_n` low for several edges while presenting valid +3 pairs, and checks that the lamp stays dark. After release, it checks that exactly two more qualifying pairs are needed to light the lamp, which shows that none of the pairs offered under reset was counted. A reset applied while the lamp is lit is also judged: the lamp must drop at once, and the count must start over.

// File: rtl/pair_lamp_pkg.sv
package pair_lamp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_LIT  = 2'b10
  } lamp_state_e;
endpackage

// File: rtl/pair_match_detect.sv
module pair_match_detect #(
  parameter int DIFF_W = 7,
  parameter int TARGET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [DIFF_W-1:0] diff_i,
  output logic              hit_o
);
  localparam logic [DIFF_W-1:0] MATCH     = DIFF_W'(TARGET);
  localparam logic [DIFF_W-1:0] NEG_MATCH = DIFF_W'(-TARGET);

  always_comb begin
    hit_o = 1'b0;
    if (valid_i) begin
      hit_o = (diff_i == MATCH);
    end
  end

  // R4: no strobe, no event
  p_strobe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !hit_o);

  // R3: mirrored difference never qualifies
  p_neg_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_i == NEG_MATCH) |-> !hit_o);
endmodule

// File: rtl/pair_lamp_seq.sv
module pair_lamp_seq
  import pair_lamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic lamp_o
);
  lamp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (hit_i) begin
      unique case (state_q)
        ST_IDLE: state_d = ST_ONE;
        ST_ONE:  state_d = ST_LIT;
        ST_LIT:  state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (hit_i) begin
      state_q <= state_d;
    end
  end

  assign lamp_o = (state_q == ST_LIT);

  // R5: second event lights the lamp
  p_lamp_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ONE && hit_i) |=> lamp_o);

  // R7: third event darkens the lamp
  p_lamp_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_o && hit_i) |=> !lamp_o);

  // R6: non-events leave the count alone
  p_hold_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> $stable(state_q));

  // R8: after the fall the count is back at zero
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_o && hit_i) |=> (state_q == ST_IDLE));

  // R1: encoding stays within the three legal states
  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'b11);
endmodule

// File: rtl/pair_match_lamp.sv
module pair_match_lamp #(
  parameter int DIFF_W = 7,
  parameter int TARGET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_valid_i,
  input  logic [DIFF_W-1:0] pair_diff_i,
  output logic              lamp_o
);
  logic hit;

  pair_match_detect #(
    .DIFF_W (DIFF_W),
    .TARGET (TARGET)
  ) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (pair_valid_i),
    .diff_i  (pair_diff_i),
    .hit_o   (hit)
  );

  pair_lamp_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .lamp_o (lamp_o)
  );
endmodule

// File: tb/tb_pair_match_lamp.sv
module tb_pair_match_lamp;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pair_valid_i;
  logic [6:0] pair_diff_i;
  logic       lamp_o;

  int total = 0;
  int bad   = 0;
  int model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_match_lamp dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_valid_i (pair_valid_i),
    .pair_diff_i  (pair_diff_i),
    .lamp_o       (lamp_o)
  );

  task automatic check(input string tag, input logic exp);
    total++;
    if (lamp_o !== exp) begin
      bad++;
      $display("FAIL %s lamp=%0b expected=%0b", tag, lamp_o, exp);
    end
  endtask

  task automatic send(input logic [6:0] d, input logic v, input string tag);
    @(negedge clk);
    pair_diff_i  = d;
    pair_valid_i = v;
    @(negedge clk);
    pair_valid_i = 1'b0;
    pair_diff_i  = 7'd0;
    if (v && d == 7'd3) model = (model == 2) ? 0 : model + 1;
    check(tag, model == 2);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0;
    model = 0;
    @(negedge clk);
    check("R1 lamp under reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lamp after release", 1'b0);
  endtask

  task automatic t_consecutive;
    send(7'd3, 1'b1, "R2 first +3");
    send(7'd3, 1'b1, "R5 second +3 lights");
  endtask

  task automatic t_hold;
    send(7'b1111101, 1'b1, "R3 -3 while lit");
    send(7'd5, 1'b1, "R3 +5 while lit");
    send(7'd0, 1'b1, "R3 zero while lit");
    send(7'd3, 1'b0, "R4 +3 without strobe");
    send(7'd3, 1'b1, "R7 third +3 darkens");
  endtask

  task automatic t_spread;
    send(7'd3, 1'b1, "R6 first spread");
    send(7'd1, 1'b1, "R6 gap +1");
    send(7'b1111101, 1'b1, "R3 gap -3");
    send(7'd127, 1'b1, "R6 gap -1");
    send(7'd3, 1'b0, "R4 gap unstrobed +3");
    send(7'd3, 1'b1, "R6 second spread lights");
    send(7'd3, 1'b1, "R7 spread third darkens");
  endtask

  task automatic t_restart;
    send(7'd3, 1'b1, "R8 one after restart");
    send(7'd4, 1'b1, "R8 gap after restart");
    send(7'd3, 1'b1, "R8 relights");
    send(7'd3, 1'b1, "R8 darkens again");
  endtask

  task automatic t_reset_collide;
    @(negedge clk);
    rst_n        = 1'b0;
    pair_valid_i = 1'b1;
    pair_diff_i  = 7'd3;
    model        = 0;
    repeat (3) @(negedge clk);
    check("R1 qualifying pairs under reset", 1'b0);
    pair_valid_i = 1'b0;
    pair_diff_i  = 7'd0;
    rst_n        = 1'b1;
    send(7'd3, 1'b1, "R1 first after release");
    send(7'd3, 1'b1, "R1 second after release lights");
    @(negedge clk);
    rst_n = 1'b0;
    model = 0;
    #1;
    check("R1 reset drops lit lamp", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    send(7'd3, 1'b1, "R1 count restarted after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    pair_valid_i = 1'b0;
    pair_diff_i  = 7'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_consecutive();
    t_hold();
    t_spread();
    t_restart();
    t_reset_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule